// File: doc/BRIEF.md
# Tap Edge Drift Estimator

This block estimates where the rising edge of one delay-line tap sits within the system clock period, relative to a reference signal, by statistical sampling. A two-bit pair, made of the reference level and the tap level, arrives from a sampling strobe that is unrelated to the system clock. Because the strobe is unrelated, every phase of the period is equally likely to be caught. The pair passes through a two-flop synchronizer. During a measurement window of a fixed, power-of-two number of system clock cycles, the block takes one synchronized sample per cycle. It counts only the samples in which the reference is high and the tap is low.

The pattern count, divided by the window length and multiplied by the clock period in picoseconds, gives the current edge position. The block subtracts a stored baseline edge from this value. It then presents the signed drift together with a rise mark and a drop mark, which a downstream stage uses to judge the temperature trend. An external timer pulses the start input once per timer period. The first pulse comes one period after initial calibration, and that calibration loads the baseline through its own port.

Top module: `edge_drift_estimator`

## Requirements
- R1: While reset is high and after it is released, done, edge_ps, delta, rise and drop are all zero until the first measurement completes.
- R2: Only samples whose pair equals 2'b10 (bit 1 is the reference level, bit 0 is the tap level) are counted. Patterns 2'b11, 2'b01 and 2'b00 add nothing.
- R3: edge_ps equals floor(hits × PERIOD_PS / 2^SAMPLE_LOG2), where hits is the number of counted samples in a window of 2^SAMPLE_LOG2 samples. Its value never exceeds PERIOD_PS.
- R4: delta equals edge_ps minus the stored baseline, as a two's-complement value of DELTA_W bits.
- R5: rise is 1 exactly when delta is positive, drop is 1 exactly when delta is negative, and both are 0 when delta is zero.
- R6: done is a one-cycle pulse. edge_ps, delta, rise and drop update on the same edge that raises done, and they hold their values until the next completion.
- R7: done rises on the (2^SAMPLE_LOG2 + 2)-th clock edge counted from the edge that accepts start, with the accepting edge counted as the first. That edge clears the count, the next 2^SAMPLE_LOG2 edges each take one sample, and one more edge registers the result.
- R8: A start pulse that arrives while a measurement is in progress is ignored. That measurement's timing and result are unchanged, and no extra done pulse follows.
- R9: When base_load is high on a clock edge, base_value becomes the baseline used by every later completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Timer pulse requesting a measurement |
| base_load | input | 1 | Load strobe for the baseline edge |
| base_value | input | EDGE_W | Baseline edge in picoseconds |
| pair_in | input | 2 | Strobe-captured pair: bit 1 reference, bit 0 tap |
| done | output | 1 | One-cycle completion pulse |
| edge_ps | output | EDGE_W | Measured edge position in picoseconds |
| delta | output | DELTA_W | Signed drift: edge minus baseline |
| rise | output | 1 | Positive drift mark |
| drop | output | 1 | Negative drift mark |

## Verification
The bench builds the block with SAMPLE_LOG2 = 4 and PERIOD_PS = 2500, which gives a 16-sample window. With a window this short, every achievable hit count from 0 to 16 can be swept completely. Each hit count is produced by a periodic stimulus whose period divides the window, so the count does not depend on how the synchronizer delay aligns with the window. For every count, baselines equal to, above and below the measured edge, together with 0 and the full period, exercise all three mark outcomes and the signed extremes of delta. Some runs also add a start pulse in the middle of the measurement.

// File: rtl/edge_est_pkg.sv
package edge_est_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } est_state_e;

    // Pair layout: bit 1 = reference level, bit 0 = tap level.
    localparam logic [1:0] RISE_PAIR = 2'b10;

    typedef struct packed {
        logic rise;
        logic drop;
    } trend_t;

    function automatic logic is_rise_pair(input logic [1:0] pair);
        return pair == RISE_PAIR;
    endfunction

endpackage

// File: rtl/pair_sync.sv
module pair_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d_async[b]};
        end
        assign q_sync[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/hit_counter.sv
module hit_counter #(
    parameter int SAMPLE_LOG2 = 10,
    parameter int CNT_W       = SAMPLE_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic             hit,
    output logic [CNT_W-1:0] hits,
    output logic             last
);
    localparam int NSAMP = 1 << SAMPLE_LOG2;

    logic [SAMPLE_LOG2-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx  <= '0;
            hits <= '0;
        end else if (enable) begin
            idx  <= idx + SAMPLE_LOG2'(1);
            hits <= hits + CNT_W'(hit);
        end
    end

    assign last = enable && (idx == SAMPLE_LOG2'(NSAMP - 1));

    assert_hits_bound_R3: assert property (@(posedge clk) disable iff (rst)
        hits <= CNT_W'(NSAMP));
endmodule

// File: rtl/edge_compare.sv
module edge_compare
    import edge_est_pkg::*;
#(
    parameter int SAMPLE_LOG2 = 10,
    parameter int PERIOD_PS   = 2500,
    parameter int EDGE_W      = 12,
    parameter int DELTA_W     = EDGE_W + 1,
    parameter int CNT_W       = SAMPLE_LOG2 + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      fire,
    input  logic [CNT_W-1:0]          hits,
    input  logic [EDGE_W-1:0]         baseline,
    output logic                      done,
    output logic [EDGE_W-1:0]         edge_ps,
    output logic signed [DELTA_W-1:0] delta,
    output trend_t                    trend
);
    localparam int PROD_W = CNT_W + EDGE_W;

    logic [PROD_W-1:0]         prod;
    logic [EDGE_W-1:0]         edge_calc;
    logic signed [DELTA_W-1:0] diff;

    always_comb begin
        prod      = PROD_W'(hits) * PROD_W'(PERIOD_PS);
        edge_calc = EDGE_W'(prod >> SAMPLE_LOG2);
        diff      = DELTA_W'($signed({1'b0, edge_calc})) - DELTA_W'($signed({1'b0, baseline}));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            edge_ps <= '0;
            delta   <= '0;
            trend   <= '0;
        end else begin
            done <= fire;
            if (fire) begin
                edge_ps    <= edge_calc;
                delta      <= diff;
                trend.rise <= diff > 0;
                trend.drop <= diff < 0;
            end
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(delta) && $stable(edge_ps) && $stable(trend)));
    assert_marks_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(trend.rise && trend.drop));
    assert_edge_range_R3: assert property (@(posedge clk) disable iff (rst)
        edge_ps <= EDGE_W'(PERIOD_PS));
endmodule

// File: rtl/edge_drift_estimator.sv
module edge_drift_estimator
    import edge_est_pkg::*;
#(
    parameter int SAMPLE_LOG2 = 10,
    parameter int PERIOD_PS   = 2500,
    parameter int EDGE_W      = $clog2(PERIOD_PS + 1),
    parameter int DELTA_W     = EDGE_W + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      base_load,
    input  logic [EDGE_W-1:0]         base_value,
    input  logic [1:0]                pair_in,
    output logic                      done,
    output logic [EDGE_W-1:0]         edge_ps,
    output logic signed [DELTA_W-1:0] delta,
    output logic                      rise,
    output logic                      drop
);
    localparam int CNT_W = SAMPLE_LOG2 + 1;

    est_state_e        state;
    logic [1:0]        pair_s;
    logic [CNT_W-1:0]  hits;
    logic              last;
    logic              accept;
    logic [EDGE_W-1:0] baseline;
    trend_t            trend;

    pair_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_async(pair_in), .q_sync(pair_s)
    );

    assign accept = (state == ST_IDLE) && start;

    hit_counter #(.SAMPLE_LOG2(SAMPLE_LOG2), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .clear(accept), .enable(state == ST_RUN),
        .hit(is_rise_pair(pair_s)), .hits(hits), .last(last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            baseline <= '0;
        end else begin
            if (base_load) baseline <= base_value;
            unique case (state)
                ST_IDLE: if (start) state <= ST_RUN;
                ST_RUN:  if (last)  state <= ST_FIN;
                ST_FIN:             state <= ST_IDLE;
                default:            state <= ST_IDLE;
            endcase
        end
    end

    edge_compare #(
        .SAMPLE_LOG2(SAMPLE_LOG2), .PERIOD_PS(PERIOD_PS),
        .EDGE_W(EDGE_W), .DELTA_W(DELTA_W), .CNT_W(CNT_W)
    ) u_cmp (
        .clk(clk), .rst(rst), .fire(state == ST_FIN), .hits(hits),
        .baseline(baseline), .done(done), .edge_ps(edge_ps),
        .delta(delta), .trend(trend)
    );

    assign rise = trend.rise;
    assign drop = trend.drop;

    assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && start && !last) |=> (state == ST_RUN));
    assert_done_after_finish_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN) |=> done);
endmodule

// File: tb/edge_drift_estimator_tb.sv
module edge_drift_estimator_tb;
    localparam int LOG2  = 4;
    localparam int NS    = 1 << LOG2;
    localparam int PER   = 2500;
    localparam int EW    = 12;
    localparam int DW    = 13;
    localparam int LAT   = NS + 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic                 base_load = 1'b0;
    logic [EW-1:0]        base_value = '0;
    logic [1:0]           pair_in = 2'b00;
    logic                 done;
    logic [EW-1:0]        edge_ps;
    logic signed [DW-1:0] delta;
    logic                 rise, drop;

    int n_chk = 0;
    int n_bad = 0;
    int jsel  = 0;
    int tick  = 0;

    edge_drift_estimator #(.SAMPLE_LOG2(LOG2), .PERIOD_PS(PER)) u_dut (
        .clk(clk), .rst(rst), .start(start), .base_load(base_load),
        .base_value(base_value), .pair_in(pair_in), .done(done),
        .edge_ps(edge_ps), .delta(delta), .rise(rise), .drop(drop)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // periodic stimulus: jsel of every 16 cycles carry pattern 10, the rest cycle through 11/01/00
    initial forever begin
        @(negedge clk);
        tick++;
        if ((tick % NS) < jsel) pair_in = 2'b10;
        else case (tick % 3)
            0: pair_in = 2'b11;
            1: pair_in = 2'b01;
            default: pair_in = 2'b00;
        endcase
    end

    task automatic measure(input int j, input int base, input bit busy_start);
        int k;
        int exp_edge;
        int exp_delta;
        bit got;
        @(negedge clk);
        base_load = 1'b1; base_value = EW'(base);
        @(negedge clk);
        base_load = 1'b0;
        jsel = j;
        repeat (4) @(negedge clk);
        start = 1'b1;
        k = 0; got = 1'b0;
        while (k < 100 && !got) begin
            @(negedge clk);
            k++;
            if (k == 1) start = 1'b0;
            if (busy_start && k == 5) start = 1'b1;
            if (busy_start && k == 6) start = 1'b0;
            if (done) got = 1'b1;
        end
        exp_edge  = (j * PER) / NS;
        exp_delta = exp_edge - base;
        check("R7 latency", k, LAT);
        check("R3 edge", int'(edge_ps), exp_edge);
        check("R4 delta", int'(delta), exp_delta);
        check("R5 rise", int'(rise), int'(exp_delta > 0));
        check("R5 drop", int'(drop), int'(exp_delta < 0));
        if (j == 0) check("R2 only 10 counted", int'(edge_ps), 0);
        @(negedge clk);
        check("R6 done pulse", int'(done), 0);
        check("R6 hold delta", int'(delta), exp_delta);
        if (busy_start) begin
            got = 1'b0;
            for (int w = 0; w < 30; w++) begin
                @(negedge clk);
                if (done) got = 1'b1;
            end
            check("R8 no extra done", int'(got), 0);
            check("R8 result kept", int'(edge_ps), exp_edge);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done", int'(done), 0);
        check("R1 edge", int'(edge_ps), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 delta", int'(delta), 0);
        check("R1 marks", int'({rise, drop}), 0);
        for (int j = 0; j <= NS; j++) begin
            int e = (j * PER) / NS;
            measure(j, e, 1'b0);
            measure(j, 0, 1'b0);
            measure(j, PER, j == 5);
            measure(j, (e < PER) ? e + 1 : e - 1, 1'b0);
        end
        // R9: new baseline used by the following completion
        measure(8, 1000, 1'b0);
        measure(8, 1300, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule